// File: doc/BRIEF.md
# Direct-Mapped Split TLB Translation Checker

This block translates the virtual addresses of a small 32-bit core through two direct-mapped tables: one holds instruction-side entries and one holds data-side entries. Both tables are indexed by the same slice of the virtual page number. Each entry has two words. The match word holds the virtual page and a valid flag. The translate word holds the physical page and the permission flags.

Every lookup reads one instruction entry and one data entry at the same index and evaluates them together. When their physical pages disagree, the entry that the access type does not need is discarded. The two entries then grant execute, read and write rights for the current privilege level. The result is registered and appears one cycle after the request. It carries the physical address, the granted rights, and either success or a two-bit fault code. A fault also records the faulting virtual address and cancels any load-linked reservation.

Entries are loaded through a synchronous write port. When translation is switched off, the address passes straight through with full rights.

Top module: `tlb_xlate_unit`

## Requirements
- R1: The table index is virtual address bits [18:13] (8 KiB pages, 64 entries per table). The same index selects one instruction entry and one data entry.
- R2: If the two translate words at the index hold different physical pages (bits [31:13]), the unused entry is treated as all-zero: the data entry for a fetch, the instruction entry for a load or store.
- R3: An entry counts only when match-word bit 0 (valid) is set and match-word bits [31:13] equal the request's address bits [31:13].
- R4: Granted rights are rsp_perm (bit 0 read, bit 1 write, bit 2 execute). Execute comes from instruction translate bit 5 (supervisor) or bit 4 (user). Read comes from data translate bit 5/4, and write from data translate bit 7/6. req_super picks the supervisor or user bit, and each right is masked by its entry counting.
- R5: rsp_paddr is the OR of both surviving translate words in bits [31:13], joined with virtual address bits [12:0].
- R6: req_kind 00 is a fetch and needs execute, 10 is a store and needs write, and 01 or 11 is a load and needs read. rsp_ok is set exactly when the needed right is granted.
- R7: On failure rsp_code is 10 (instruction page fault) or 11 (data page fault) when a counting entry covered the needed right. Otherwise it is 00 (instruction TLB miss) or 01 (data TLB miss). rsp_code is 00 on success.
- R8: With xlate_en low, rsp_paddr equals the virtual address, rsp_perm is 111, rsp_ok is set, and no fault is raised.
- R9: A fault loads fault_addr with the request's virtual address and sets lock_addr to all ones. rsv_set without a fault loads lock_addr with rsv_addr. After reset lock_addr is all ones and fault_addr is zero.
- R10: A request accepted at one clock edge produces rsp_valid for exactly the following cycle. rsp_fault pulses for that one cycle only when the request failed.
- R11: A table write takes effect at the clock edge that samples it, so a lookup in the same cycle sees the old entry. Reset clears every entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Entry write strobe |
| wr_sel | input | 1 | Table select: 0 instruction, 1 data |
| wr_idx | input | 6 | Entry index to write |
| wr_match | input | 32 | Match word (page bits and valid bit 0) |
| wr_xlate | input | 32 | Translate word (physical page and rights) |
| xlate_en | input | 1 | Translation enable |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 00 fetch, 01 load, 10 store, 11 load |
| req_super | input | 1 | Supervisor privilege |
| rsv_set | input | 1 | Load-linked reservation set |
| rsv_addr | input | 32 | Reservation address |
| rsp_valid | output | 1 | Response present |
| rsp_paddr | output | 32 | Physical address |
| rsp_perm | output | 3 | Granted rights {x, w, r} |
| rsp_ok | output | 1 | Lookup succeeded |
| rsp_fault | output | 1 | One-cycle fault strobe |
| rsp_code | output | 2 | Fault class |
| fault_addr | output | 32 | Captured faulting address |
| lock_addr | output | 32 | Reservation address, all ones when cancelled |

## Verification
Several relations are checked on every cycle:
- each response follows exactly one request;
- success and fault exclude each other;
- a successful lookup always grants the right its access type needs;
- the page offset always passes through;
- bypass mode always returns the address unchanged with full rights;
- a fault always captures the address and cancels the reservation;
- a table write always lands.

Only the bench's sweeps can show that the page-conflict discard, the privilege bit choice, the physical page merge and the miss-versus-page-fault classification are right for each combination of entry contents. The same holds for the old-entry-visible timing of a write.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    // access kinds
    localparam logic [1:0] KIND_FETCH = 2'b00;
    localparam logic [1:0] KIND_LOAD  = 2'b01;
    localparam logic [1:0] KIND_STORE = 2'b10;

    // rights vector bit positions
    localparam int RIGHT_R = 0;
    localparam int RIGHT_W = 1;
    localparam int RIGHT_X = 2;

    // translate word right flags
    localparam int XT_USER_X  = 4;
    localparam int XT_SUPER_X = 5;
    localparam int XT_USER_R  = 4;
    localparam int XT_SUPER_R = 5;
    localparam int XT_USER_W  = 6;
    localparam int XT_SUPER_W = 7;

    // match word valid flag
    localparam int MW_VALID = 0;

    typedef enum logic [1:0] {
        FC_IMISS = 2'b00,
        FC_DMISS = 2'b01,
        FC_IPAGE = 2'b10,
        FC_DPAGE = 2'b11
    } fault_code_e;

    function automatic logic [2:0] need_of(input logic [1:0] kind);
        logic [2:0] n;
        n = '0;
        if (kind == KIND_FETCH)      n[RIGHT_X] = 1'b1;
        else if (kind == KIND_STORE) n[RIGHT_W] = 1'b1;
        else                         n[RIGHT_R] = 1'b1;
        return n;
    endfunction
endpackage

// File: rtl/tlb_entry_table.sv
module tlb_entry_table #(
    parameter int WORD_W = 32,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_match,
    input  logic [WORD_W-1:0] wr_xlate,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_match,
    output logic [WORD_W-1:0] rd_xlate
);
    localparam int DEPTH = 1 << IDX_W;

    logic [WORD_W-1:0] match_q [DEPTH];
    logic [WORD_W-1:0] match_d [DEPTH];
    logic [WORD_W-1:0] xlate_q [DEPTH];
    logic [WORD_W-1:0] xlate_d [DEPTH];

    always_comb begin
        match_d = match_q;
        xlate_d = xlate_q;
        if (wr_en) begin
            match_d[wr_idx] = wr_match;
            xlate_d[wr_idx] = wr_xlate;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                match_q[i] <= '0;
                xlate_q[i] <= '0;
            end
        end else begin
            match_q <= match_d;
            xlate_q <= xlate_d;
        end
    end

    assign rd_match = match_q[rd_idx];
    assign rd_xlate = xlate_q[rd_idx];

    // R11: a sampled write is visible from the next cycle on
    a_r11_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (match_q[$past(wr_idx)] == $past(wr_match)) &&
                  (xlate_q[$past(wr_idx)] == $past(wr_xlate)));
endmodule

// File: rtl/tlb_perm_eval.sv
module tlb_perm_eval
    import tlb_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int OFFSET_W = 13
) (
    input  logic [ADDR_W-1:0] vaddr,
    input  logic [2:0]        need,
    input  logic              super_mode,
    input  logic [ADDR_W-1:0] imatch,
    input  logic [ADDR_W-1:0] ixlate,
    input  logic [ADDR_W-1:0] dmatch,
    input  logic [ADDR_W-1:0] dxlate,
    output logic [ADDR_W-1:0] paddr,
    output logic [2:0]        grant,
    output logic              hit,
    output logic [1:0]        code
);
    localparam int PAGE_W = ADDR_W - OFFSET_W;

    logic [ADDR_W-1:0] im_eff, it_eff, dm_eff, dt_eff, merged;
    logic [2:0]        counted;
    logic              ent_i, ent_d, covered;

    always_comb begin
        im_eff = imatch;
        it_eff = ixlate;
        dm_eff = dmatch;
        dt_eff = dxlate;
        // R2: drop the unneeded side on a physical page conflict
        if (ixlate[ADDR_W-1 -: PAGE_W] != dxlate[ADDR_W-1 -: PAGE_W]) begin
            if (need[RIGHT_X]) begin
                dm_eff = '0;
                dt_eff = '0;
            end else begin
                im_eff = '0;
                it_eff = '0;
            end
        end

        // R3: valid and page-equal
        ent_i = im_eff[MW_VALID] &&
                (im_eff[ADDR_W-1 -: PAGE_W] == vaddr[ADDR_W-1 -: PAGE_W]);
        ent_d = dm_eff[MW_VALID] &&
                (dm_eff[ADDR_W-1 -: PAGE_W] == vaddr[ADDR_W-1 -: PAGE_W]);

        counted          = '0;
        counted[RIGHT_X] = ent_i;
        counted[RIGHT_R] = ent_d;
        counted[RIGHT_W] = ent_d;

        // R4: privilege selects the flag set
        grant          = '0;
        grant[RIGHT_X] = super_mode ? it_eff[XT_SUPER_X] : it_eff[XT_USER_X];
        grant[RIGHT_R] = super_mode ? dt_eff[XT_SUPER_R] : dt_eff[XT_USER_R];
        grant[RIGHT_W] = super_mode ? dt_eff[XT_SUPER_W] : dt_eff[XT_USER_W];
        grant          = grant & counted;

        // R5: merged physical page plus untranslated offset
        merged = it_eff | dt_eff;
        paddr  = {merged[ADDR_W-1 -: PAGE_W], vaddr[OFFSET_W-1:0]};

        // R6 / R7
        hit     = |(need & grant);
        covered = |(need & counted);
        if (hit)
            code = FC_IMISS;
        else if (covered)
            code = need[RIGHT_X] ? FC_IPAGE : FC_DPAGE;
        else
            code = need[RIGHT_X] ? FC_IMISS : FC_DMISS;
    end
endmodule

// File: rtl/tlb_xlate_unit.sv
module tlb_xlate_unit
    import tlb_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int OFFSET_W = 13,
    parameter int IDX_W    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_match,
    input  logic [ADDR_W-1:0] wr_xlate,
    input  logic              xlate_en,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [1:0]        req_kind,
    input  logic              req_super,
    input  logic              rsv_set,
    input  logic [ADDR_W-1:0] rsv_addr,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic [2:0]        rsp_perm,
    output logic              rsp_ok,
    output logic              rsp_fault,
    output logic [1:0]        rsp_code,
    output logic [ADDR_W-1:0] fault_addr,
    output logic [ADDR_W-1:0] lock_addr
);
    localparam int N_TABLES = 2;
    localparam int SEL_I    = 0;
    localparam int SEL_D    = 1;

    typedef struct packed {
        logic              vld;
        logic              ok;
        logic              fault;
        logic [1:0]        code;
        logic [ADDR_W-1:0] paddr;
        logic [2:0]        perm;
        logic [ADDR_W-1:0] faddr;
        logic [ADDR_W-1:0] lock;
    } unit_state_t;

    unit_state_t state_d, state_q;

    logic [IDX_W-1:0]  look_idx;
    logic [ADDR_W-1:0] tbl_match [N_TABLES];
    logic [ADDR_W-1:0] tbl_xlate [N_TABLES];
    logic [2:0]        need;
    logic [ADDR_W-1:0] ev_paddr;
    logic [2:0]        ev_grant;
    logic              ev_hit;
    logic [1:0]        ev_code;

    // R1: index taken just above the page offset
    assign look_idx = req_vaddr[OFFSET_W +: IDX_W];
    assign need     = need_of(req_kind);

    for (genvar g = 0; g < N_TABLES; g++) begin : g_tbl
        tlb_entry_table #(
            .WORD_W(ADDR_W),
            .IDX_W (IDX_W)
        ) u_tbl (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en && (wr_sel == 1'(g))),
            .wr_idx  (wr_idx),
            .wr_match(wr_match),
            .wr_xlate(wr_xlate),
            .rd_idx  (look_idx),
            .rd_match(tbl_match[g]),
            .rd_xlate(tbl_xlate[g])
        );
    end

    tlb_perm_eval #(
        .ADDR_W  (ADDR_W),
        .OFFSET_W(OFFSET_W)
    ) u_eval (
        .vaddr     (req_vaddr),
        .need      (need),
        .super_mode(req_super),
        .imatch    (tbl_match[SEL_I]),
        .ixlate    (tbl_xlate[SEL_I]),
        .dmatch    (tbl_match[SEL_D]),
        .dxlate    (tbl_xlate[SEL_D]),
        .paddr     (ev_paddr),
        .grant     (ev_grant),
        .hit       (ev_hit),
        .code      (ev_code)
    );

    always_comb begin
        state_d       = state_q;
        state_d.vld   = req_valid;
        state_d.fault = 1'b0;
        if (req_valid) begin
            if (!xlate_en) begin
                // R8: bypass
                state_d.paddr = req_vaddr;
                state_d.perm  = 3'b111;
                state_d.ok    = 1'b1;
                state_d.code  = FC_IMISS;
            end else begin
                state_d.paddr = ev_paddr;
                state_d.perm  = ev_grant;
                state_d.ok    = ev_hit;
                state_d.code  = ev_code;
                state_d.fault = !ev_hit;
            end
        end
        // R9: a fault overrides a new reservation
        if (state_d.fault) begin
            state_d.faddr = req_vaddr;
            state_d.lock  = '1;
        end else if (rsv_set) begin
            state_d.lock  = rsv_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= '0;
            state_q.lock <= '1;
        end else begin
            state_q <= state_d;
        end
    end

    assign rsp_valid  = state_q.vld;
    assign rsp_paddr  = state_q.paddr;
    assign rsp_perm   = state_q.perm;
    assign rsp_ok     = state_q.ok && state_q.vld;
    assign rsp_fault  = state_q.fault;
    assign rsp_code   = state_q.code;
    assign fault_addr = state_q.faddr;
    assign lock_addr  = state_q.lock;

    // R10: one response per request, one cycle later
    a_r10_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == $past(req_valid));

    a_r10_fault_only_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_valid);

    // R7: success and fault are exclusive
    a_r7_ok_or_fault: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_ok != rsp_fault));

    // R6: success implies the needed right is granted
    a_r6_ok_has_right: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ok) |->
            (($past(req_kind) == KIND_FETCH) ? rsp_perm[RIGHT_X] :
             ($past(req_kind) == KIND_STORE) ? rsp_perm[RIGHT_W] :
                                               rsp_perm[RIGHT_R]));

    // R5: page offset is never translated
    a_r5_offset_passes: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_paddr[OFFSET_W-1:0] == $past(req_vaddr[OFFSET_W-1:0])));

    // R8: bypass returns the address with full rights
    a_r8_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !$past(xlate_en)) |->
            (rsp_paddr == $past(req_vaddr)) && (rsp_perm == 3'b111) && !rsp_fault);

    // R9: fault captures address and kills reservation
    a_r9_fault_capture: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (fault_addr == $past(req_vaddr)) && (&lock_addr));
endmodule

// File: tb/test_tlb_xlate_unit.sv
module test_tlb_xlate_unit;
    localparam int AW = 32;
    localparam int OW = 13;
    localparam int IW = 6;
    localparam int D  = 1 << IW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_en, wr_sel;
    logic [IW-1:0] wr_idx;
    logic [AW-1:0] wr_match, wr_xlate;
    logic          xlate_en, req_valid, req_super, rsv_set;
    logic [AW-1:0] req_vaddr, rsv_addr;
    logic [1:0]    req_kind;
    logic          rsp_valid, rsp_ok, rsp_fault;
    logic [AW-1:0] rsp_paddr, fault_addr, lock_addr;
    logic [2:0]    rsp_perm;
    logic [1:0]    rsp_code;

    always #5 clk = ~clk;

    tlb_xlate_unit i_tlb_xlate_unit (.*);

    int n_chk = 0;
    int n_err = 0;
    logic [AW-1:0] m_im [D], m_it [D], m_dm [D], m_dt [D];
    logic [AW-1:0] e_faddr, e_lock;

    task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    task automatic wr(input logic sel, input logic [IW-1:0] idx,
                      input logic [AW-1:0] m, input logic [AW-1:0] t);
        wr_en = 1'b1; wr_sel = sel; wr_idx = idx; wr_match = m; wr_xlate = t;
        @(negedge clk);
        wr_en = 1'b0;
        if (sel) begin m_dm[idx] = m; m_dt[idx] = t; end
        else     begin m_im[idx] = m; m_it[idx] = t; end
    endtask

    task automatic rsv(input logic [AW-1:0] a);
        rsv_set = 1'b1; rsv_addr = a;
        @(negedge clk);
        rsv_set = 1'b0;
        e_lock = a;
    endtask

    // reference from the requirement text
    task automatic model(input logic [AW-1:0] va, input logic [1:0] kind, input logic sup,
                         output logic [AW-1:0] pa, output logic [2:0] perm,
                         output logic ok, output logic [1:0] code);
        logic [AW-1:0] im, it, dm, dt;
        logic [IW-1:0] ix;
        logic fetch, store, ci, cd, cov;
        ix = va[OW +: IW];
        im = m_im[ix]; it = m_it[ix]; dm = m_dm[ix]; dt = m_dt[ix];
        fetch = (kind == 2'b00);
        store = (kind == 2'b10);
        if ((it >> OW) != (dt >> OW)) begin
            if (fetch) begin dm = 0; dt = 0; end
            else       begin im = 0; it = 0; end
        end
        ci = im[0] && ((im >> OW) == (va >> OW));
        cd = dm[0] && ((dm >> OW) == (va >> OW));
        perm[2] = ci && (sup ? it[5] : it[4]);
        perm[0] = cd && (sup ? dt[5] : dt[4]);
        perm[1] = cd && (sup ? dt[7] : dt[6]);
        pa = (((it | dt) >> OW) << OW) | (va % (1 << OW));
        ok  = fetch ? perm[2] : store ? perm[1] : perm[0];
        cov = fetch ? ci : cd;
        if (ok)       code = 2'b00;
        else if (cov) code = fetch ? 2'b10 : 2'b11;
        else          code = fetch ? 2'b00 : 2'b01;
    endtask

    task automatic req_chk(input string tag, input logic [AW-1:0] va,
                           input logic [1:0] kind, input logic sup);
        logic [AW-1:0] pa;
        logic [2:0]    pm;
        logic          ok;
        logic [1:0]    cd;
        if (xlate_en) model(va, kind, sup, pa, pm, ok, cd);
        else begin pa = va; pm = 3'b111; ok = 1'b1; cd = 2'b00; end
        req_valid = 1'b1; req_vaddr = va; req_kind = kind; req_super = sup;
        @(negedge clk);
        req_valid = 1'b0;
        if (!ok) begin e_faddr = va; e_lock = '1; end
        chk({tag, " R10 rsp_valid"}, 32'(rsp_valid), 32'd1);
        chk({tag, " R5 paddr"}, rsp_paddr, pa);
        chk({tag, " R4 perm"}, 32'(rsp_perm), 32'(pm));
        chk({tag, " R6 ok"}, 32'(rsp_ok), 32'(ok));
        chk({tag, " R7 fault"}, 32'(rsp_fault), 32'(!ok));
        chk({tag, " R7 code"}, 32'(rsp_code), 32'(cd));
        chk({tag, " R9 fault_addr"}, fault_addr, e_faddr);
        chk({tag, " R9 lock_addr"}, lock_addr, e_lock);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [AW-1:0] va, m, it, dt;
        logic [7:0] pat;
        rst_n = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; wr_idx = '0; wr_match = '0; wr_xlate = '0;
        xlate_en = 1'b1; req_valid = 1'b0; req_vaddr = '0; req_kind = '0; req_super = 1'b0;
        rsv_set = 1'b0; rsv_addr = '0;
        for (int i = 0; i < D; i++) begin m_im[i] = 0; m_it[i] = 0; m_dm[i] = 0; m_dt[i] = 0; end
        e_faddr = '0; e_lock = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state (R9, R10)
        chk("R10 reset rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R9 reset lock_addr", lock_addr, '1);
        chk("R9 reset fault_addr", fault_addr, '0);
        // R11: cleared table misses
        req_chk("R11 empty table", 32'h1234_5678, 2'b01, 1'b1);

        // R1: entry at index 9 hits only addresses with bits [18:13] = 9
        va = {13'h0ABC, 6'd9, 13'h0123};
        wr(1'b1, 6'd9, {va[31:13], 13'h1}, {19'h5_5555, 13'h0FF0});
        req_chk("R1 index hit", va, 2'b01, 1'b1);
        req_chk("R1 other index", {13'h0ABC, 6'd10, 13'h0123}, 2'b01, 1'b1);

        // R11: write and lookup in the same cycle sees old entry
        va = {13'h0111, 6'd20, 13'h0004};
        wr_en = 1'b1; wr_sel = 1'b1; wr_idx = 6'd20;
        wr_match = {va[31:13], 13'h1}; wr_xlate = {19'h0_1234, 13'h00F0};
        req_valid = 1'b1; req_vaddr = va; req_kind = 2'b01; req_super = 1'b0;
        @(negedge clk);
        wr_en = 1'b0; req_valid = 1'b0;
        chk("R11 same-cycle write old entry", 32'(rsp_ok), 32'd0);
        e_faddr = va; e_lock = '1;
        m_dm[20] = {va[31:13], 13'h1}; m_dt[20] = {19'h0_1234, 13'h00F0};
        req_chk("R11 write visible next", va, 2'b01, 1'b0);

        // R3: valid bit clear on a matching entry is a miss
        wr(1'b1, 6'd20, {va[31:13], 13'h0}, {19'h0_1234, 13'h00F0});
        req_chk("R3 invalid entry", va, 2'b01, 1'b0);

        // R2: conflicting pages, each side used alone
        va = {13'h0222, 6'd30, 13'h0777};
        wr(1'b0, 6'd30, {va[31:13], 13'h1}, {19'h0_0AAA, 13'h0030});
        wr(1'b1, 6'd30, {va[31:13], 13'h1}, {19'h0_0BBB, 13'h00F0});
        req_chk("R2 fetch keeps instr", va, 2'b00, 1'b1);
        req_chk("R2 load keeps data", va, 2'b01, 1'b1);
        req_chk("R2 store keeps data", va, 2'b10, 1'b0);
        req_chk("R6 kind 11 is load", va, 2'b11, 1'b1);

        // R8: bypass, including an address that would fault
        xlate_en = 1'b0;
        req_chk("R8 bypass a", 32'hDEAD_BEEF, 2'b10, 1'b0);
        req_chk("R8 bypass b", 32'h0000_0001, 2'b00, 1'b1);
        xlate_en = 1'b1;

        // R9: success keeps reservation, fault cancels it
        rsv(32'h0000_4440);
        chk("R9 reservation set", lock_addr, 32'h0000_4440);
        req_chk("R9 success keeps lock", va, 2'b01, 1'b1);
        req_chk("R9 fault cancels lock", 32'hFFFF_E000, 2'b10, 1'b1);

        // sweep: contents from the case number (R1 R2 R3 R4 R5 R6 R7)
        for (int c = 0; c < 256; c++) begin
            logic [IW-1:0] ix;
            ix  = 6'(c * 5 + 3);
            pat = 8'(c * 37 + 11);
            va  = {5'(c >> 3), 8'(c), ix, 13'(c * 97)};
            m   = {va[31:13], 13'h0};
            it  = {19'(c * 131 + 7), 9'h0, pat[3:0], 4'h0};
            dt  = c[4] ? {it[31:13], 13'h0} : {it[31:13] ^ 19'h1, 13'h0};
            dt[7:4] = pat[7:4];
            wr(1'b0, ix, (c[1] ? m : m ^ 32'h0008_0000) | 32'(c[0]), it);
            wr(1'b1, ix, (c[3] ? m : m ^ 32'h0010_0000) | 32'(c[2]), dt);
            if (c[5]) rsv(va ^ 32'h10);
            for (int k = 0; k < 3; k++) begin
                for (int s = 0; s < 2; s++) begin
                    req_chk("sweep R2 R3", va, 2'(k), 1'(s));
                end
            end
            @(negedge clk);
            chk("R10 strobe drops", 32'({rsp_valid, rsp_fault}), 32'd0);
        end

        finish_run();
    end
endmodule